// File: doc/BRIEF.md
# Multi-Mode Interrupt Line Controller

This block takes a small, parameterised set of interrupt request lines and combines them into one registered interrupt output for a single CPU. Software sets each line to one of three trigger styles. In edge style, qualifying transitions are latched and must be acknowledged. In level style, the request follows the input and the mask and nothing is latched. In end-of-interrupt style, the request is level based, but once the CPU claims the line it is not delivered again until software writes the line's index to the end-of-interrupt register.

Every input passes through a two-flop synchroniser first. A claim register gives the CPU the lowest-numbered line that is ready for delivery. All configuration goes through a simple synchronous bus, and read data returns one cycle after the read strobe.

Top module: `irq_line_ctrl`

## Requirements
- R1: After reset every line is masked, no line is pending, every line is in level mode with an active-high input, `cpu_irq` is 0, and a claim read returns all ones.
- R2: In edge mode, the line's 2-bit edge field (bit 0 rising, bit 1 falling, both bits set for either direction) chooses which transitions latch a pending event. A transition that is not selected latches nothing.
- R3: Writing a 1 to a line's bit in the acknowledge register (offset 4) clears that line's pending event. An edge that latches in the same cycle as the acknowledge stays pending.
- R4: In level mode, the line requests service while its synchronised input equals its active level. The polarity bit gives the level: 0 means active-high and 1 means active-low. The request drops when the input goes inactive.
- R5: A masked line (mask bit 1) never raises `cpu_irq` and is never returned by a claim read. Clearing the mask of a line whose input is active raises `cpu_irq` in the cycle after the write.
- R6: In end-of-interrupt mode, a claim read that returns the line marks it in service, and `cpu_irq` drops while its input stays active. Writing the line's index to offset 5 re-enables delivery with no mask change.
- R7: `cpu_irq` is a registered OR of all deliverable lines. A level input change shows on it on the third rising edge, and an edge event shows on it on the fourth rising edge.
- R8: A claim read (offset 6) returns the index of the lowest-numbered deliverable line, or all ones if no line is deliverable. `rd_valid` and `rd_data` arrive one cycle after `rd_en`.
- R9: Register offsets are: mode 0 (2 bits per line: 00 level, 01 edge, 10 end-of-interrupt), edge field 1 (2 bits per line, reset 01), polarity 2, mask 3. All four read back what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Asynchronous interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register offset |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |

## Verification
A register write takes effect at its own clock edge, so mask, polarity and end-of-interrupt changes show on `cpu_irq` one edge later. A claim read affects `cpu_irq` on the edge after the read. Input changes take three edges to reach `cpu_irq` in level style and four in edge style. The bench drives on falling edges and counts those edges exactly. It checks that the output is still low one edge early and high on the due edge. Read results go into a queue and are compared when `rd_valid` appears. The acknowledge race is timed so that the new edge latches on the same edge as the acknowledge write.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam logic [1:0] TRIG_LEVEL = 2'b00;
  localparam logic [1:0] TRIG_EDGE  = 2'b01;
  localparam logic [1:0] TRIG_EOI   = 2'b10;

  localparam int REG_MODE  = 0;
  localparam int REG_EDGE  = 1;
  localparam int REG_POL   = 2;
  localparam int REG_MASK  = 3;
  localparam int REG_ACK   = 4;
  localparam int REG_EOI   = 5;
  localparam int REG_CLAIM = 6;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_lvl,
  input  logic [1:0] mode,
  input  logic [1:0] edge_sel,
  input  logic       act_low,
  input  logic       masked,
  input  logic       ack,
  input  logic       eoi,
  input  logic       claim,
  output logic       deliver
);
  logic prev_q, pend_q, insvc_q;
  logic is_edge, is_eoi, is_lvl;
  logic rise, fall, edge_hit, active, req;

  assign is_edge  = (mode == TRIG_EDGE);
  assign is_eoi   = (mode == TRIG_EOI);
  assign is_lvl   = !is_edge && !is_eoi;
  assign rise     = sync_lvl & ~prev_q;
  assign fall     = ~sync_lvl & prev_q;
  assign edge_hit = is_edge & ((edge_sel[0] & rise) | (edge_sel[1] & fall));
  assign active   = sync_lvl ^ act_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      pend_q  <= 1'b0;
      insvc_q <= 1'b0;
    end else begin
      prev_q  <= sync_lvl;
      pend_q  <= is_edge & ((pend_q & ~ack) | edge_hit);
      insvc_q <= is_eoi & ((insvc_q & ~eoi) | claim);
    end
  end

  always_comb begin
    if (is_edge)     req = pend_q;
    else if (is_eoi) req = active & ~insvc_q;
    else             req = active;
  end

  assign deliver = req & ~masked;

  // a qualifying edge is never lost, even when acked in the same cycle
  assert_edge_kept_R3: assert property (@(posedge clk) disable iff (rst)
    edge_hit |=> pend_q);

  // claim in end-of-interrupt mode marks the line in service
  assert_claim_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    (is_eoi && claim) |=> insvc_q);

  // level mode holds no latched state
  assert_level_stateless_R4: assert property (@(posedge clk) disable iff (rst)
    is_lvl |=> (!pend_q && !insvc_q));
endmodule

// File: rtl/irq_claim_pick.sv
module irq_claim_pick #(
  parameter int NUM_LINES = 4,
  parameter int IDX_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] ready,
  output logic                 any,
  output logic [IDX_W-1:0]     idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (ready[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  assert_pick_valid_R8: assert property (@(posedge clk) disable iff (rst)
    any |-> ready[idx]);

  assert_pick_none_R8: assert property (@(posedge clk) disable iff (rst)
    !any |-> (ready == '0));
endmodule

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_valid,
  output logic                 cpu_irq
);
  localparam int IDX_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int FIELD_W = 2 * NUM_LINES;

  logic [FIELD_W-1:0]   mode_q, edge_q;
  logic [NUM_LINES-1:0] pol_q, mask_q;
  logic [NUM_LINES-1:0] sync_lvl, ack_vec, eoi_vec, claim_vec, ready;
  logic                 pick_any;
  logic [IDX_W-1:0]     pick_idx;
  logic                 wr_mode, wr_edge, wr_pol, wr_mask, wr_ack, wr_eoi, rd_claim;

  assign wr_mode  = wr_en && (addr == ADDR_W'(REG_MODE));
  assign wr_edge  = wr_en && (addr == ADDR_W'(REG_EDGE));
  assign wr_pol   = wr_en && (addr == ADDR_W'(REG_POL));
  assign wr_mask  = wr_en && (addr == ADDR_W'(REG_MASK));
  assign wr_ack   = wr_en && (addr == ADDR_W'(REG_ACK));
  assign wr_eoi   = wr_en && (addr == ADDR_W'(REG_EOI));
  assign rd_claim = rd_en && (addr == ADDR_W'(REG_CLAIM));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      edge_q <= {NUM_LINES{2'b01}};
      pol_q  <= '0;
      mask_q <= '1;
    end else begin
      if (wr_mode) mode_q <= wr_data[FIELD_W-1:0];
      if (wr_edge) edge_q <= wr_data[FIELD_W-1:0];
      if (wr_pol)  pol_q  <= wr_data[NUM_LINES-1:0];
      if (wr_mask) mask_q <= wr_data[NUM_LINES-1:0];
    end
  end

  assign ack_vec = wr_ack ? wr_data[NUM_LINES-1:0] : '0;

  irq_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (irq_in),
    .sync_out (sync_lvl)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign eoi_vec[g]   = wr_eoi && (wr_data == DATA_W'(g));
    assign claim_vec[g] = rd_claim && pick_any && (pick_idx == IDX_W'(g));

    irq_line_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .sync_lvl (sync_lvl[g]),
      .mode     (mode_q[2*g +: 2]),
      .edge_sel (edge_q[2*g +: 2]),
      .act_low  (pol_q[g]),
      .masked   (mask_q[g]),
      .ack      (ack_vec[g]),
      .eoi      (eoi_vec[g]),
      .claim    (claim_vec[g]),
      .deliver  (ready[g])
    );
  end

  irq_claim_pick #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_pick (
    .clk   (clk),
    .rst   (rst),
    .ready (ready),
    .any   (pick_any),
    .idx   (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      cpu_irq  <= |ready;
      rd_valid <= rd_en;
      if (rd_en) begin
        case (int'(addr))
          REG_MODE:  rd_data <= DATA_W'(mode_q);
          REG_EDGE:  rd_data <= DATA_W'(edge_q);
          REG_POL:   rd_data <= DATA_W'(pol_q);
          REG_MASK:  rd_data <= DATA_W'(mask_q);
          REG_CLAIM: rd_data <= pick_any ? DATA_W'(pick_idx) : '1;
          default:   rd_data <= '0;
        endcase
      end
    end
  end

  assert_irq_follows_R7: assert property (@(posedge clk) disable iff (rst)
    (|ready) |=> cpu_irq);

  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !(|ready) |=> !cpu_irq);

  assert_all_masked_R5: assert property (@(posedge clk) disable iff (rst)
    (&mask_q) |=> !cpu_irq);

  assert_read_latency_R8: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

// File: tb/tb_irq_line_ctrl.sv
module tb_irq_line_ctrl;
  localparam int N  = 4;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam logic [DW-1:0] NONE = '1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_in = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid, cpu_irq;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #2 clk = ~clk;

  irq_line_ctrl #(.NUM_LINES(N), .DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .cpu_irq(cpu_irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [DW-1:0] d);
    wr_en = 1'b1; addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input int a, input logic [DW-1:0] exp, input string tag);
    rd_en = 1'b1; addr = AW'(a);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: compare read results against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected read actual=%h expected=none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic irq_is(input string tag, input logic exp);
    check(tag, {31'b0, cpu_irq}, {31'b0, exp});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    irq_is("R1 irq after reset", 1'b0);
    bus_read(3, 32'hF, "R1 mask reset");
    bus_read(0, 32'h0, "R1 mode reset");
    bus_read(1, 32'h55, "R1 edge field reset");
    bus_read(6, NONE, "R1 claim empty");

    // R4/R7 level mode, active high
    bus_write(3, 32'hB);
    irq_in[2] = 1'b1;
    tick(2); irq_is("R7 level not yet", 1'b0);
    tick(1); irq_is("R7 level third edge", 1'b1);
    bus_read(6, 32'd2, "R8 claim line2");
    irq_in[2] = 1'b0;
    tick(3); irq_is("R4 level drops", 1'b0);
    bus_write(2, 32'h4);
    tick(1); irq_is("R4 active low", 1'b1);
    bus_write(2, 32'h0);
    tick(1); irq_is("R4 back to high", 1'b0);

    // R5 mask
    bus_write(3, 32'hF);
    irq_in[2] = 1'b1;
    tick(4); irq_is("R5 masked quiet", 1'b0);
    bus_read(6, NONE, "R5 masked not claimed");
    bus_write(3, 32'hB);
    irq_is("R5 not before unmask edge", 1'b0);
    tick(1); irq_is("R5 unmask next cycle", 1'b1);
    irq_in[2] = 1'b0;
    bus_write(3, 32'hF);
    tick(4);

    // R2/R3 edge mode on line 1
    bus_write(0, 32'h4);
    bus_write(3, 32'hD);
    irq_in[1] = 1'b1;
    tick(3); irq_is("R7 edge not yet", 1'b0);
    tick(1); irq_is("R2 rising latched", 1'b1);
    bus_write(4, 32'h2);
    tick(1); irq_is("R3 ack clears", 1'b0);
    irq_in[1] = 1'b0;
    tick(4); irq_is("R2 falling ignored", 1'b0);
    bus_write(1, 32'h59);
    irq_in[1] = 1'b1;
    tick(4); irq_is("R2 rising ignored", 1'b0);
    irq_in[1] = 1'b0;
    tick(4); irq_is("R2 falling latched", 1'b1);
    bus_write(4, 32'h2);
    tick(1);
    bus_write(1, 32'h5D);
    irq_in[1] = 1'b1;
    tick(4); irq_is("R2 both rising", 1'b1);
    bus_write(4, 32'h2);
    tick(1); irq_is("R3 ack with input high", 1'b0);
    irq_in[1] = 1'b0;
    tick(4); irq_is("R2 both falling", 1'b1);
    // R3 race: new edge latches on the same edge as the ack
    irq_in[1] = 1'b1;
    tick(2);
    bus_write(4, 32'h2);
    tick(1); irq_is("R3 edge during ack kept", 1'b1);
    bus_write(4, 32'h2);
    tick(1); irq_is("R3 second ack clears", 1'b0);
    irq_in[1] = 1'b0;
    bus_write(3, 32'hF);
    tick(4);

    // R6 end-of-interrupt mode on line 0
    bus_write(0, 32'h2);
    bus_write(3, 32'hE);
    irq_in[0] = 1'b1;
    tick(3); irq_is("R6 eoi line delivered", 1'b1);
    bus_read(6, 32'd0, "R6 claim line0");
    irq_is("R6 irq before claim edge effect", 1'b1);
    tick(1); irq_is("R6 blocked after claim", 1'b0);
    tick(5); irq_is("R6 still blocked", 1'b0);
    bus_read(6, NONE, "R6 blocked not claimable");
    bus_write(5, 32'd0);
    tick(1); irq_is("R6 eoi resumes", 1'b1);
    irq_in[0] = 1'b0;
    tick(3); irq_is("R6 input gone", 1'b0);

    // R8 priority, R9 readback
    bus_write(0, 32'h0);
    irq_in = 4'b1010;
    bus_write(3, 32'h0);
    tick(3); irq_is("R8 two lines", 1'b1);
    bus_read(6, 32'd1, "R8 lowest index");
    bus_write(3, 32'h2);
    bus_read(6, 32'd3, "R8 next index");
    bus_write(3, 32'hA);
    bus_read(6, NONE, "R8 none left");
    tick(1); irq_is("R5 all requesters masked", 1'b0);
    bus_write(2, 32'h5);
    bus_read(2, 32'h5, "R9 polarity readback");
    bus_write(0, 32'h9);
    bus_read(0, 32'h9, "R9 mode readback");
    bus_read(3, 32'hA, "R9 mask readback");
    tick(2);
    check("R8 scoreboard drained", DW'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule